// File: doc/BRIEF.md
# Indirect Configuration Register Bank for a Dual-Channel Disk Controller

This block holds the per-channel configuration of a two-channel disk interface controller. Each channel owns a bank of seven registers: two base addresses, a general configuration byte, a 10-bit read-ahead preload with its control byte, and two access-timing bytes. Software does not see these registers directly. It writes a byte-wide pointer to choose a bank and an index, and then reads or writes a word-wide data port that reaches the chosen register.

The pointer can also be told to step its index after every data-port access. This lets software sweep a whole bank with one pointer write. The pointer carries three bus-behaviour bits as well, and the block drives them straight out. Every stored field is decoded onto output pins for the rest of the controller. A write that sets the FIFO-clear bit produces a one-cycle pulse and stores nothing.

Top module: `ixcfg_regbank`

## Requirements
- R1: After reset the pointer reads 0x50. Bit layout: bit7 auto-step, bit6 wait state, bit5 burst disable (reads as 0), bit4 medium select timing, bit3 bank, bits2..0 index. The outputs are wait_state_o=1, burst_off_o=0 and devsel_med_o=1.
- R2: After reset, bank b (0 or 1) holds these values: index 0 = 0x1F0 - b*0x80, index 4 = 0x3F6 - b*0x80, index 1 = 0x01, index 5 = 0xF5, index 6 = 0xDE, and index 2 and index 3 = 0.
- R3: Pointer bits2..0 pick the index and bit3 picks the bank. A data write changes only the selected register of the selected bank; the other bank stays as it was.
- R4: When pointer bit7 is 1, the index steps by one after each data-port read or write, and it wraps from 7 to 0. When bit7 is 0, the index does not change.
- R5: These bits always read as 0: the whole of index 2, index 3 and index 7, bit2 of index 1, and bit5 of the pointer. Pointer bit5 still drives burst_off_o.
- R6: Indices 1, 2, 3, 5 and 6 store only the low 8 bits of a write, and their reads return 0 in bits15..8. Indices 0 and 4 store and return all 16 bits.
- R7: Index 1 bits drive these per-bank outputs: bit7 dma_en, bit6 drv_reset, bit5 iordy_en, bit4 narrow_port, bit3 irq_low, bit2 pwr_save, bit1 bus_master, bit0 io_en.
- R8: The read-ahead count is {index3[1:0], index2[7:0]}. Index 3 bit7 drives ra_en and bit4 drives mode4.
- R9: Writing index 3 with bit6 = 1 raises fifo_clr_o for that bank for exactly one cycle, in the cycle after the write. The bit is not stored.
- R10: A data read returns the selected register in the same cycle, with no register in the path. A data write takes effect at the next clock edge.
- R11: If a pointer write and a data access happen in the same cycle, the data access uses the old pointer. The pointer then loads the written value without stepping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ptr_wr_i | input | 1 | Pointer write strobe |
| ptr_wdata_i | input | 8 | Pointer write value |
| ptr_rdata_o | output | 8 | Pointer readback |
| dat_wr_i | input | 1 | Data-port write strobe |
| dat_rd_i | input | 1 | Data-port read strobe (for auto-step) |
| dat_wdata_i | input | 16 | Data-port write value |
| dat_rdata_o | output | 16 | Data-port read value |
| wait_state_o | output | 1 | Posted-write wait state request |
| burst_off_o | output | 1 | Master burst disable |
| devsel_med_o | output | 1 | Medium select timing |
| cmd_base_o | output | 32 | Command block base, bank b at [16b+15:16b] |
| ctl_base_o | output | 32 | Control block base, bank b at [16b+15:16b] |
| dma_en_o | output | 2 | DMA enable per bank |
| drv_reset_o | output | 2 | Drive reset per bank |
| iordy_en_o | output | 2 | Ready-line enable per bank |
| narrow_port_o | output | 2 | 8-bit data port per bank |
| irq_low_o | output | 2 | Active-low interrupt per bank |
| pwr_save_o | output | 2 | Power save per bank |
| bus_master_o | output | 2 | Bus-master mode per bank |
| io_en_o | output | 2 | I/O port enable per bank |
| ra_count_o | output | 20 | Read-ahead preload, bank b at [10b+9:10b] |
| ra_en_o | output | 2 | Read-ahead enable per bank |
| mode4_o | output | 2 | Mode-4 timing per bank |
| fifo_clr_o | output | 2 | One-cycle FIFO clear pulse per bank |
| data_tim_o | output | 16 | Data port timing, bank b at [8b+7:8b] |
| cmd_tim_o | output | 16 | Command port timing, bank b at [8b+7:8b] |

## Verification
Some rules are checked by assertions on every cycle:
- the index steps or holds according to the auto-step bit and the strobes;
- a pointer write loads exactly the written fields;
- a bank that is not written keeps all of its contents;
- the FIFO-clear pulse comes only from a qualifying write;
- write-only locations and upper bytes read as zero.

Other behaviours need the bench scenarios: the reset values per bank, the exact bit position of every decoded field, the assembly of the 10-bit count, the 7-to-0 wrap seen through a full sweep, and the ordering when a pointer write and a data access collide.

// File: rtl/ixcfg_pkg.sv
package ixcfg_pkg;
    localparam int IDXW   = 3;
    localparam int BANKW  = 1;
    localparam int NBANK  = 1 << BANKW;
    localparam int WORDW  = 16;
    localparam int BYTEW  = 8;
    localparam int RAHW   = 2;
    localparam int RAW    = BYTEW + RAHW;

    localparam logic [IDXW-1:0] IX_CMD  = 3'd0;
    localparam logic [IDXW-1:0] IX_GEN  = 3'd1;
    localparam logic [IDXW-1:0] IX_RALO = 3'd2;
    localparam logic [IDXW-1:0] IX_RACF = 3'd3;
    localparam logic [IDXW-1:0] IX_CTL  = 3'd4;
    localparam logic [IDXW-1:0] IX_DTIM = 3'd5;
    localparam logic [IDXW-1:0] IX_CTIM = 3'd6;

    localparam logic [WORDW-1:0] CMD_BASE0 = 16'h01F0;
    localparam logic [WORDW-1:0] CTL_BASE0 = 16'h03F6;
    localparam logic [WORDW-1:0] BANK_STEP = 16'h0080;
    localparam logic [BYTEW-1:0] GEN_RST   = 8'h01;
    localparam logic [BYTEW-1:0] DTIM_RST  = 8'hF5;
    localparam logic [BYTEW-1:0] CTIM_RST  = 8'hDE;
    localparam logic [BYTEW-1:0] GEN_RDMSK = 8'hFB;

    typedef struct packed {
        logic            autoinc;
        logic            wait1;
        logic            burst_off;
        logic            devsel_med;
        logic [BANKW-1:0] bank;
        logic [IDXW-1:0] idx;
    } ptr_t;

    typedef struct packed {
        logic [WORDW-1:0] cmd_base;
        logic [BYTEW-1:0] gen;
        logic [BYTEW-1:0] ra_lo;
        logic [RAHW-1:0]  ra_hi;
        logic             ra_en;
        logic             mode4;
        logic [WORDW-1:0] ctl_base;
        logic [BYTEW-1:0] dtim;
        logic [BYTEW-1:0] ctim;
        logic             fifo_clr;
    } bank_t;

    function automatic logic [WORDW-1:0] bank_base(logic [WORDW-1:0] base0, int b);
        return base0 - (WORDW'(b) * BANK_STEP);
    endfunction
endpackage

// File: rtl/ixcfg_ptr.sv
module ixcfg_ptr
    import ixcfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [BYTEW-1:0] wdata_i,
    input  logic             acc_i,
    output ptr_t             ptr_o
);
    ptr_t ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (wr_i) begin
            ptr_d.autoinc    = wdata_i[7];
            ptr_d.wait1      = wdata_i[6];
            ptr_d.burst_off  = wdata_i[5];
            ptr_d.devsel_med = wdata_i[4];
            ptr_d.bank       = wdata_i[3 +: BANKW];
            ptr_d.idx        = wdata_i[IDXW-1:0];
        end else if (acc_i && ptr_q.autoinc) begin
            ptr_d.idx = ptr_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '{autoinc: 1'b0, wait1: 1'b1, burst_off: 1'b0,
                       devsel_med: 1'b1, bank: '0, idx: '0};
        end else begin
            ptr_q <= ptr_d;
        end
    end

    assign ptr_o = ptr_q;

    // R4: index steps by one (wrapping) after an access in auto-step mode
    p_idx_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_i && ptr_q.autoinc && !wr_i) |=> (ptr_q.idx == $past(ptr_q.idx) + 3'd1));

    // R4: without a pointer write and without auto-step, the pointer holds
    p_idx_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_i && !(acc_i && ptr_q.autoinc)) |=> $stable(ptr_q));

    // R11: a pointer write loads the written value, never a stepped one
    p_ptr_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (ptr_q.idx == $past(wdata_i[2:0]) && ptr_q.autoinc == $past(wdata_i[7])));
endmodule

// File: rtl/ixcfg_bank.sv
module ixcfg_bank
    import ixcfg_pkg::*;
#(
    parameter int BANK = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [IDXW-1:0]  idx_i,
    input  logic [WORDW-1:0] wdata_i,
    output logic [WORDW-1:0] rdata_o,
    output bank_t            st_o
);
    bank_t bk_d, bk_q;

    always_comb begin
        bk_d = bk_q;
        bk_d.fifo_clr = 1'b0;
        if (wr_i) begin
            case (idx_i)
                IX_CMD:  bk_d.cmd_base = wdata_i;
                IX_GEN:  bk_d.gen      = wdata_i[BYTEW-1:0];
                IX_RALO: bk_d.ra_lo    = wdata_i[BYTEW-1:0];
                IX_RACF: begin
                    bk_d.ra_en    = wdata_i[7];
                    bk_d.fifo_clr = wdata_i[6];
                    bk_d.mode4    = wdata_i[4];
                    bk_d.ra_hi    = wdata_i[RAHW-1:0];
                end
                IX_CTL:  bk_d.ctl_base = wdata_i;
                IX_DTIM: bk_d.dtim     = wdata_i[BYTEW-1:0];
                IX_CTIM: bk_d.ctim     = wdata_i[BYTEW-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bk_q <= '{cmd_base: bank_base(CMD_BASE0, BANK), gen: GEN_RST,
                      ra_lo: '0, ra_hi: '0, ra_en: 1'b0, mode4: 1'b0,
                      ctl_base: bank_base(CTL_BASE0, BANK), dtim: DTIM_RST,
                      ctim: CTIM_RST, fifo_clr: 1'b0};
        end else begin
            bk_q <= bk_d;
        end
    end

    always_comb begin
        case (idx_i)
            IX_CMD:  rdata_o = bk_q.cmd_base;
            IX_GEN:  rdata_o = {{(WORDW-BYTEW){1'b0}}, bk_q.gen & GEN_RDMSK};
            IX_CTL:  rdata_o = bk_q.ctl_base;
            IX_DTIM: rdata_o = {{(WORDW-BYTEW){1'b0}}, bk_q.dtim};
            IX_CTIM: rdata_o = {{(WORDW-BYTEW){1'b0}}, bk_q.ctim};
            default: rdata_o = '0;
        endcase
    end

    assign st_o = bk_q;

    // R3: an unwritten bank keeps every stored field
    p_bank_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> ($stable(bk_q.cmd_base) && $stable(bk_q.gen) && $stable(bk_q.ra_lo)
                  && $stable(bk_q.ra_hi) && $stable(bk_q.ra_en) && $stable(bk_q.mode4)
                  && $stable(bk_q.ctl_base) && $stable(bk_q.dtim) && $stable(bk_q.ctim)));

    // R9: the clear pulse only follows a write of index 3 with bit 6 set
    p_fifo_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bk_q.fifo_clr |-> $past(wr_i && idx_i == IX_RACF && wdata_i[6]));

    // R9: no clear pulse without a write in the previous cycle
    p_fifo_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> !bk_q.fifo_clr);
endmodule

// File: rtl/ixcfg_regbank.sv
module ixcfg_regbank
    import ixcfg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ptr_wr_i,
    input  logic [7:0]           ptr_wdata_i,
    output logic [7:0]           ptr_rdata_o,
    input  logic                 dat_wr_i,
    input  logic                 dat_rd_i,
    input  logic [15:0]          dat_wdata_i,
    output logic [15:0]          dat_rdata_o,
    output logic                 wait_state_o,
    output logic                 burst_off_o,
    output logic                 devsel_med_o,
    output logic [31:0]          cmd_base_o,
    output logic [31:0]          ctl_base_o,
    output logic [1:0]           dma_en_o,
    output logic [1:0]           drv_reset_o,
    output logic [1:0]           iordy_en_o,
    output logic [1:0]           narrow_port_o,
    output logic [1:0]           irq_low_o,
    output logic [1:0]           pwr_save_o,
    output logic [1:0]           bus_master_o,
    output logic [1:0]           io_en_o,
    output logic [19:0]          ra_count_o,
    output logic [1:0]           ra_en_o,
    output logic [1:0]           mode4_o,
    output logic [1:0]           fifo_clr_o,
    output logic [15:0]          data_tim_o,
    output logic [15:0]          cmd_tim_o
);
    ptr_t             ptr;
    logic [WORDW-1:0] rd_bank [NBANK];
    bank_t            st [NBANK];

    ixcfg_ptr u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (ptr_wr_i),
        .wdata_i (ptr_wdata_i),
        .acc_i   (dat_wr_i | dat_rd_i),
        .ptr_o   (ptr)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        ixcfg_bank #(.BANK(b)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_i    (dat_wr_i && (ptr.bank == BANKW'(b))),
            .idx_i   (ptr.idx),
            .wdata_i (dat_wdata_i),
            .rdata_o (rd_bank[b]),
            .st_o    (st[b])
        );

        assign cmd_base_o[b*WORDW +: WORDW] = st[b].cmd_base;
        assign ctl_base_o[b*WORDW +: WORDW] = st[b].ctl_base;
        assign dma_en_o[b]      = st[b].gen[7];
        assign drv_reset_o[b]   = st[b].gen[6];
        assign iordy_en_o[b]    = st[b].gen[5];
        assign narrow_port_o[b] = st[b].gen[4];
        assign irq_low_o[b]     = st[b].gen[3];
        assign pwr_save_o[b]    = st[b].gen[2];
        assign bus_master_o[b]  = st[b].gen[1];
        assign io_en_o[b]       = st[b].gen[0];
        assign ra_count_o[b*RAW +: RAW] = {st[b].ra_hi, st[b].ra_lo};
        assign ra_en_o[b]       = st[b].ra_en;
        assign mode4_o[b]       = st[b].mode4;
        assign fifo_clr_o[b]    = st[b].fifo_clr;
        assign data_tim_o[b*BYTEW +: BYTEW] = st[b].dtim;
        assign cmd_tim_o[b*BYTEW +: BYTEW]  = st[b].ctim;
    end

    assign dat_rdata_o  = rd_bank[ptr.bank];
    assign ptr_rdata_o  = {ptr.autoinc, ptr.wait1, 1'b0, ptr.devsel_med, ptr.bank, ptr.idx};
    assign wait_state_o = ptr.wait1;
    assign burst_off_o  = ptr.burst_off;
    assign devsel_med_o = ptr.devsel_med;

    // R5: write-only and unused indices read as zero
    p_wo_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_rdata_o[2:0] == 3'd2 || ptr_rdata_o[2:0] == 3'd3 || ptr_rdata_o[2:0] == 3'd7)
        |-> (dat_rdata_o == 16'h0000));

    // R6: byte-wide indices never return an upper byte
    p_hi_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_rdata_o[2:0] != 3'd0 && ptr_rdata_o[2:0] != 3'd4) |-> (dat_rdata_o[15:8] == 8'h00));

    // R5: pointer bit 5 never reads back
    p_ptr_b5_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_rdata_o[5] == 1'b0);
endmodule

// File: tb/sim_ixcfg_regbank.sv
module sim_ixcfg_regbank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ptr_wr = 1'b0;
    logic [7:0]  ptr_wdata = '0;
    logic [7:0]  ptr_rdata;
    logic        dat_wr = 1'b0;
    logic        dat_rd = 1'b0;
    logic [15:0] dat_wdata = '0;
    logic [15:0] dat_rdata;
    logic        wait_state, burst_off, devsel_med;
    logic [31:0] cmd_base, ctl_base;
    logic [1:0]  dma_en, drv_reset, iordy_en, narrow_port, irq_low, pwr_save, bus_master, io_en;
    logic [19:0] ra_count;
    logic [1:0]  ra_en, mode4, fifo_clr;
    logic [15:0] data_tim, cmd_tim;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ixcfg_regbank u0 (
        .clk(clk), .rst_n(rst_n),
        .ptr_wr_i(ptr_wr), .ptr_wdata_i(ptr_wdata), .ptr_rdata_o(ptr_rdata),
        .dat_wr_i(dat_wr), .dat_rd_i(dat_rd), .dat_wdata_i(dat_wdata), .dat_rdata_o(dat_rdata),
        .wait_state_o(wait_state), .burst_off_o(burst_off), .devsel_med_o(devsel_med),
        .cmd_base_o(cmd_base), .ctl_base_o(ctl_base),
        .dma_en_o(dma_en), .drv_reset_o(drv_reset), .iordy_en_o(iordy_en),
        .narrow_port_o(narrow_port), .irq_low_o(irq_low), .pwr_save_o(pwr_save),
        .bus_master_o(bus_master), .io_en_o(io_en),
        .ra_count_o(ra_count), .ra_en_o(ra_en), .mode4_o(mode4), .fifo_clr_o(fifo_clr),
        .data_tim_o(data_tim), .cmd_tim_o(cmd_tim)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic ptr_write(logic [7:0] v);
        @(negedge clk);
        ptr_wr = 1'b1; ptr_wdata = v;
        @(negedge clk);
        ptr_wr = 1'b0;
    endtask

    task automatic dat_write(logic [15:0] v);
        @(negedge clk);
        dat_wr = 1'b1; dat_wdata = v;
        @(negedge clk);
        dat_wr = 1'b0;
    endtask

    task automatic dat_read(output logic [15:0] v);
        @(negedge clk);
        dat_rd = 1'b1;
        #1 v = dat_rdata;
        @(negedge clk);
        dat_rd = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 ptr reset", {24'd0, ptr_rdata}, 32'h50);
        check("R1 bus bits", {29'd0, wait_state, burst_off, devsel_med}, 32'b101);
        check("R2 bank0 cmd base", {16'd0, cmd_base[15:0]}, 32'h1F0);
        check("R2 bank0 ctl base", {16'd0, ctl_base[15:0]}, 32'h3F6);
        check("R2 bank0 gen", {24'd0, dma_en[0], drv_reset[0], iordy_en[0], narrow_port[0],
              irq_low[0], pwr_save[0], bus_master[0], io_en[0]}, 32'h01);
        check("R2 timings", {data_tim, cmd_tim}, {16'hF5F5, 16'hDEDE});
        check("R2 ra zero", {10'd0, ra_count, ra_en, mode4, fifo_clr}, 32'h0);
    endtask

    task automatic t_sweep_bank1();
        logic [15:0] v;
        logic [15:0] exp [9] = '{16'h170, 16'h01, 16'h0, 16'h0, 16'h376, 16'hF5, 16'hDE, 16'h0, 16'h170};
        ptr_write(8'hD8);
        for (int i = 0; i < 9; i++) begin
            dat_read(v);
            check($sformatf("R2 R4 r4_ bank1 sweep %0d", i), {16'd0, v}, {16'd0, exp[i]});
        end
        check("R4 index after wrap", {24'd0, ptr_rdata}, 32'hD9);
        ptr_write(8'h58);
        dat_read(v);
        dat_read(v);
        check("R4 no step without bit7", {24'd0, ptr_rdata}, 32'h58);
    endtask

    task automatic t_bank_sel();
        logic [15:0] v;
        ptr_write(8'h58);
        dat_write(16'h1234);
        check("R3 bank1 written", {16'd0, cmd_base[31:16]}, 32'h1234);
        check("R3 bank0 untouched", {16'd0, cmd_base[15:0]}, 32'h1F0);
        ptr_write(8'h50);
        dat_read(v);
        check("R3 R10 bank0 read", {16'd0, v}, 32'h1F0);
        ptr_write(8'h54);
        dat_write(16'hBEEF);
        dat_read(v);
        check("R6 word index keeps 16 bits", {16'd0, v}, 32'hBEEF);
    endtask

    task automatic t_gen_cfg();
        logic [15:0] v;
        ptr_write(8'h51);
        dat_write(16'h77A5);
        check("R7 gen decode", {24'd0, dma_en[0], drv_reset[0], iordy_en[0], narrow_port[0],
              irq_low[0], pwr_save[0], bus_master[0], io_en[0]}, 32'hA5);
        check("R7 bank1 gen untouched", {30'd0, dma_en[1], io_en[1]}, 32'b01);
        dat_read(v);
        check("R5 R6 gen readback", {16'd0, v}, 32'h00A1);
        ptr_write(8'h55);
        dat_write(16'hAB3C);
        check("R6 timing byte", {24'd0, data_tim[7:0]}, 32'h3C);
    endtask

    task automatic t_readahead();
        logic [15:0] v;
        ptr_write(8'h52);
        dat_write(16'h005A);
        dat_read(v);
        check("R5 index2 reads zero", {16'd0, v}, 32'h0);
        ptr_write(8'h53);
        dat_write(16'h0083);
        dat_read(v);
        check("R5 index3 reads zero", {16'd0, v}, 32'h0);
        check("R8 count", {22'd0, ra_count[9:0]}, 32'h35A);
        check("R8 en mode4", {30'd0, ra_en[0], mode4[0]}, 32'b10);
        dat_write(16'h0090);
        check("R8 mode4 set", {30'd0, ra_en[0], mode4[0]}, 32'b11);
        check("R8 hi cleared", {22'd0, ra_count[9:0]}, 32'h05A);
        ptr_write(8'h57);
        dat_read(v);
        check("R5 index7 reads zero", {16'd0, v}, 32'h0);
    endtask

    task automatic t_fifo();
        ptr_write(8'h5B);
        dat_write(16'h00C7);
        check("R9 pulse on", {30'd0, fifo_clr}, 32'b10);
        @(negedge clk);
        check("R9 pulse one cycle", {30'd0, fifo_clr}, 32'b00);
        check("R9 other fields", {29'd0, ra_en[1], mode4[1], ra_count[19]}, 32'b101);
    endtask

    task automatic t_ptr_bits();
        ptr_write(8'h70);
        check("R5 ptr bit5 hidden", {24'd0, ptr_rdata}, 32'h50);
        check("R5 burst_off driven", {31'd0, burst_off}, 32'h1);
        ptr_write(8'h08);
        check("R1 bus bits cleared", {29'd0, wait_state, burst_off, devsel_med}, 32'b000);
    endtask

    task automatic t_collide();
        logic [15:0] v;
        ptr_write(8'hD5);
        @(negedge clk);
        ptr_wr = 1'b1; ptr_wdata = 8'h56; dat_rd = 1'b1;
        #1 v = dat_rdata;
        @(negedge clk);
        ptr_wr = 1'b0; dat_rd = 1'b0;
        check("R11 read uses old pointer", {16'd0, v}, 32'h003C);
        check("R11 pointer loaded, no step", {24'd0, ptr_rdata}, 32'h56);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sweep_bank1();
        t_bank_sel();
        t_gen_cfg();
        t_readahead();
        t_fifo();
        t_ptr_bits();
        t_collide();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule